// File: doc/BRIEF.md
# Linked-Ring Cyclic DMA Channel

This block is one DMA channel that streams data between a memory buffer and a single fixed peripheral word address. The work is described by 16-byte descriptors kept in memory. Each one holds a byte count, a source address, a destination address and a link to the next descriptor. Software points the channel at the first descriptor, asks for a fetch and sets the enable bit. From then on the channel walks the linked list by itself. Lists are normally closed into a ring, so the channel never stops on its own. It raises a completion flag each time a descriptor's count runs out.

Data moves one 32-bit word per read/write pair over a simple request/grant memory master port. The same port also carries the four descriptor reads. Each side's address either steps by 4 after every word or stays fixed, so one buffer in memory can feed a peripheral register, or be filled from one. Software controls the channel through a small 32-bit register port. That port offers pause and resume, a hard abort, a view of the descriptor in use, and a masked level interrupt.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset, irq and mem_req are 0, and every register reads 0. The registers are at byte offsets: control 0x00, next pointer 0x04, current descriptor 0x08, interrupt mask 0x0C, interrupt status 0x10.
- R2: Writing control with bit 13 set starts a fetch at the next pointer with its low 4 bits cleared. The fetch is four reads at base, base+4, base+8 and base+12, in that order, and they return byte count, source, destination and link. No data access happens before all four complete.
- R3: Each word is read at the source address and then written to the destination address. Control bits 3:2 select the source mode and bits 5:4 the destination mode. Code 00 steps the address by 4 after each word; code 10 keeps it fixed.
- R4: A byte count (up to 65536) is rounded up to whole words. A count of 10 moves exactly 3 words.
- R5: When the last word of a descriptor is written, status bit 0 is set. The channel then fetches the descriptor at the link word and carries on, so a closed ring repeats indefinitely.
- R6: irq is a registered copy of status bit 0 AND mask bit 0. Writing 0 to status bit 0 clears it, and writing 1 has no effect.
- R7: A completion that arrives while status bit 0 is already set leaves it at 1. One clear returns it to 0.
- R8: Control bit 12 enables the channel. When it is cleared, no new request is issued (a request already pending still completes). Setting it again continues with the next word, with none repeated and none skipped.
- R9: The current-descriptor register holds the aligned base of the descriptor in use. Control bit 14 reads 1 only while the channel is enabled and moving data.
- R10: Writing control with bit 20 set drops mem_req on the next clock, clears bit 14 and discards the rest of the descriptor. Enable alone does not restart the channel; a new fetch starts again from the first word of the descriptor.
- R11: A pending request keeps its address, data and direction unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid while mem_gnt is high on a read |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench builds the channel with its default 32-bit addresses and a 17-bit byte-count field, which is enough for the full 64 KiB period. Descriptors stay within a 1 KiB memory model plus one peripheral word, which keeps both closed-ring wrap-around and odd byte counts within a few hundred cycles. In some scenarios a pseudo-random grant stall is switched on, so requests are held for several cycles. That tests address stability, and it shows that pausing never loses or repeats a word.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  // register word index (byte offset >> 2)
  localparam logic [2:0] RI_CTRL = 3'd0;
  localparam logic [2:0] RI_NEXT = 3'd1;
  localparam logic [2:0] RI_CUR  = 3'd2;
  localparam logic [2:0] RI_MASK = 3'd3;
  localparam logic [2:0] RI_STAT = 3'd4;

  // control bit positions that software and the engine rely on
  localparam int CB_SRC   = 2;
  localparam int CB_DST   = 4;
  localparam int CB_EN    = 12;
  localparam int CB_FETCH = 13;
  localparam int CB_ACT   = 14;
  localparam int CB_ABORT = 20;

  typedef enum logic [1:0] {
    AM_INC  = 2'b00,
    AM_R1   = 2'b01,
    AM_HOLD = 2'b10,
    AM_R3   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ES_IDLE,
    ES_FETCH,
    ES_READ,
    ES_WRITE
  } eng_state_e;

endpackage

// File: rtl/rdc_addr_step.sv
module rdc_addr_step
  import rdc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  addr_mode_e    mode,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step && (mode != AM_HOLD)) begin
      addr <= addr + WORD_BYTES;
    end
  end

endmodule

// File: rtl/rdc_regs.sv
module rdc_regs
  import rdc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          active,
  input  logic [AW-1:0] cur_desc,
  input  logic          done,
  output logic          en,
  output logic [1:0]    src_mode,
  output logic [1:0]    dst_mode,
  output logic          fetch_go,
  output logic          abort_go,
  output logic [AW-1:0] next_ptr,
  output logic          sts,
  output logic          msk,
  output logic          irq
);

  localparam int IDX_W = RAW - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_ctrl, wr_next, wr_mask, wr_stat;
  logic [DW-1:0]    ctrl_view;

  assign idx     = reg_addr[RAW-1:2];
  assign wr_ctrl = reg_we && (idx == IDX_W'(RI_CTRL));
  assign wr_next = reg_we && (idx == IDX_W'(RI_NEXT));
  assign wr_mask = reg_we && (idx == IDX_W'(RI_MASK));
  assign wr_stat = reg_we && (idx == IDX_W'(RI_STAT));

  // one-shot commands act in the cycle of the write
  assign fetch_go = wr_ctrl && reg_wdata[CB_FETCH];
  assign abort_go = wr_ctrl && reg_wdata[CB_ABORT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      src_mode <= 2'b00;
      dst_mode <= 2'b00;
      next_ptr <= '0;
      msk      <= 1'b0;
      sts      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en       <= reg_wdata[CB_EN];
        src_mode <= reg_wdata[CB_SRC +: 2];
        dst_mode <= reg_wdata[CB_DST +: 2];
      end
      if (wr_next) next_ptr <= AW'(reg_wdata);
      if (wr_mask) msk <= reg_wdata[0];
      // a new completion wins over a clear in the same cycle
      if (done)                          sts <= 1'b1;
      else if (wr_stat && !reg_wdata[0]) sts <= 1'b0;
      irq <= sts & msk;
    end
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CB_SRC +: 2]   = src_mode;
    ctrl_view[CB_DST +: 2]   = dst_mode;
    ctrl_view[CB_EN]         = en;
    ctrl_view[CB_ACT]        = active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (idx)
        IDX_W'(RI_CTRL): reg_rdata <= ctrl_view;
        IDX_W'(RI_NEXT): reg_rdata <= DW'(next_ptr);
        IDX_W'(RI_CUR):  reg_rdata <= DW'(cur_desc);
        IDX_W'(RI_MASK): reg_rdata <= DW'(msk);
        IDX_W'(RI_STAT): reg_rdata <= DW'(sts);
        default:         reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rdc_engine.sv
module rdc_engine
  import rdc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BC_W = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic          fetch_go,
  input  logic          abort_go,
  input  logic [AW-1:0] next_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          active,
  output logic          fetching,
  output logic [AW-1:0] cur_desc,
  output logic          done
);

  localparam int WC_W = BC_W - 1;

  eng_state_e       state_q;
  logic [1:0]       fidx_q;
  logic [AW-1:0]    base_q, link_q;
  logic [WC_W-1:0]  wc_q, wc_new;
  logic [DW-1:0]    data_q;
  logic [BC_W:0]    bc_ext;
  logic             xfer_ok;

  function automatic logic [AW-1:0] align16(input logic [AW-1:0] p);
    return {p[AW-1:4], 4'h0};
  endfunction

  // byte count rounded up to whole words
  assign bc_ext  = {1'b0, mem_rdata[BC_W-1:0]} + (BC_W+1)'(3);
  assign wc_new  = bc_ext[BC_W:2];
  assign xfer_ok = mem_req && mem_gnt && !abort_go && !fetch_go;

  // source (0) and destination (1) address pointers
  logic [AW-1:0] ptr  [2];
  logic          ld   [2];
  logic          stp  [2];
  addr_mode_e    md   [2];

  assign ld[0]  = xfer_ok && (state_q == ES_FETCH) && (fidx_q == 2'd1);
  assign ld[1]  = xfer_ok && (state_q == ES_FETCH) && (fidx_q == 2'd2);
  assign stp[0] = xfer_ok && (state_q == ES_READ);
  assign stp[1] = xfer_ok && (state_q == ES_WRITE);
  assign md[0]  = addr_mode_e'(src_mode);
  assign md[1]  = addr_mode_e'(dst_mode);

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    rdc_addr_step #(.AW(AW)) u_step (
      .clk      (clk),
      .rst      (rst),
      .load     (ld[g]),
      .load_val (AW'(mem_rdata)),
      .step     (stp[g]),
      .mode     (md[g]),
      .addr     (ptr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ES_IDLE;
      fidx_q    <= '0;
      base_q    <= '0;
      link_q    <= '0;
      cur_desc  <= '0;
      wc_q      <= '0;
      data_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort_go) begin
        state_q <= ES_IDLE;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end else if (fetch_go) begin
        state_q <= ES_FETCH;
        base_q  <= align16(next_ptr);
        fidx_q  <= '0;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end else begin
        case (state_q)
          ES_FETCH: begin
            if (!mem_req) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= base_q + AW'({fidx_q, 2'b00});
            end else if (mem_gnt) begin
              mem_req <= 1'b0;
              fidx_q  <= fidx_q + 2'd1;
              if (fidx_q == 2'd0) wc_q <= wc_new;
              if (fidx_q == 2'd3) begin
                cur_desc <= base_q;
                link_q   <= AW'(mem_rdata);
                if (wc_q == '0) begin
                  done   <= 1'b1;
                  base_q <= align16(AW'(mem_rdata));
                end else begin
                  state_q <= ES_READ;
                end
              end
            end
          end
          ES_READ: begin
            if (!mem_req) begin
              if (en) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= ptr[0];
              end
            end else if (mem_gnt) begin
              mem_req <= 1'b0;
              data_q  <= mem_rdata;
              state_q <= ES_WRITE;
            end
          end
          ES_WRITE: begin
            if (!mem_req) begin
              if (en) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= ptr[1];
                mem_wdata <= data_q;
              end
            end else if (mem_gnt) begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              wc_q    <= wc_q - WC_W'(1);
              if (wc_q == WC_W'(1)) begin
                done    <= 1'b1;
                state_q <= ES_FETCH;
                base_q  <= align16(link_q);
                fidx_q  <= '0;
              end else begin
                state_q <= ES_READ;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign active   = en && ((state_q == ES_READ) || (state_q == ES_WRITE));
  assign fetching = (state_q == ES_FETCH);

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import rdc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BC_W = 17,
  parameter int RAW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           irq
);

  logic          en, fetch_go, abort_go, active, fetching, done, sts, msk;
  logic [1:0]    src_mode, dst_mode;
  logic [AW-1:0] next_ptr, cur_desc;

  rdc_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .active    (active),
    .cur_desc  (cur_desc),
    .done      (done),
    .en        (en),
    .src_mode  (src_mode),
    .dst_mode  (dst_mode),
    .fetch_go  (fetch_go),
    .abort_go  (abort_go),
    .next_ptr  (next_ptr),
    .sts       (sts),
    .msk       (msk),
    .irq       (irq)
  );

  rdc_engine #(.AW(AW), .DW(DW), .BC_W(BC_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .src_mode  (src_mode),
    .dst_mode  (dst_mode),
    .fetch_go  (fetch_go),
    .abort_go  (abort_go),
    .next_ptr  (next_ptr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .active    (active),
    .fetching  (fetching),
    .cur_desc  (cur_desc),
    .done      (done)
  );

endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_gnt,
  input logic          irq,
  input logic          sts,
  input logic          msk,
  input logic          en,
  input logic          fetch_go,
  input logic          abort_go,
  input logic          active,
  input logic          fetching,
  input logic          done
);

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(sts) & $past(msk)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !abort_go && !fetch_go)
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    abort_go |=> (!mem_req && !active));

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !mem_req && !fetching) |=> !mem_req);

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> sts);

  // R3
  we_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

endmodule

bind ring_dma_chan ring_dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt),
  .irq       (irq),
  .sts       (sts),
  .msk       (msk),
  .en        (en),
  .fetch_go  (fetch_go),
  .abort_go  (abort_go),
  .active    (active),
  .fetching  (fetching),
  .done      (done)
);

// File: tb/ring_dma_chan_tb.sv
`timescale 1ns/1ps
module ring_dma_chan_tb;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int RAW = 5;
  localparam logic [31:0] PER    = 32'h0000_0800;
  localparam logic [31:0] B_EN   = 32'h0000_1000;
  localparam logic [31:0] B_FE   = 32'h0000_2000;
  localparam logic [31:0] B_AC   = 32'h0000_4000;
  localparam logic [31:0] B_AB   = 32'h0010_0000;
  localparam logic [31:0] M2P    = 32'h0000_0020; // dst hold, src inc
  localparam logic [31:0] P2M    = 32'h0000_0008; // src hold, dst inc
  localparam logic [4:0]  O_CTRL = 5'h00, O_NEXT = 5'h04, O_CUR = 5'h08,
                          O_MASK = 5'h0C, O_STAT = 5'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic           mem_req, mem_we, mem_gnt, irq;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata;

  ring_dma_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory and peripheral model
  logic [31:0] mem [0:255];
  logic [31:0] per_seq;
  logic [31:0] per_log [0:63];
  logic [31:0] acc_log [0:63];
  int          per_n, acc_n;
  logic        stall_on = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  int          n_chk = 0;
  int          n_fail = 0;

  assign mem_gnt   = mem_req && !(stall_on && lfsr[0]);
  assign mem_rdata = (mem_addr == PER) ? per_seq : mem[mem_addr[9:2]];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_gnt) begin
      if (acc_n < 64) acc_log[acc_n] <= mem_addr;
      acc_n <= acc_n + 1;
      if (mem_we) begin
        if (mem_addr == PER) begin
          if (per_n < 64) per_log[per_n] <= mem_wdata;
          per_n <= per_n + 1;
        end else begin
          mem[mem_addr[9:2]] <= mem_wdata;
        end
      end else if (mem_addr == PER) begin
        per_seq <= per_seq + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    stall_on = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    per_n = 0; acc_n = 0; per_seq = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_per(input int n, input int lim);
    for (int i = 0; i < lim && per_n < n; i++) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] bc, src, dst, nxt);
    mem[a/4] = bc; mem[a/4+1] = src; mem[a/4+2] = dst; mem[a/4+3] = nxt;
  endtask

  // R1: reset values
  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(O_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(O_NEXT, v); chk("R1 next", v, 32'h0);
    rd(O_CUR,  v); chk("R1 cur", v, 32'h0);
    rd(O_MASK, v); chk("R1 mask", v, 32'h0);
    rd(O_STAT, v); chk("R1 stat", v, 32'h0);
  endtask

  // R2 R3 R5 R11: two-entry ring, memory to peripheral, stalled grants
  task automatic t_ring();
    logic [31:0] v;
    logic [31:0] exp8 [8] = '{32'hA0, 32'hA1, 32'hA2, 32'hB0, 32'hB1, 32'hA0, 32'hA1, 32'hA2};
    do_reset();
    put_desc(32'h40, 32'd12, 32'h100, PER, 32'h60);
    put_desc(32'h60, 32'd8,  32'h180, PER, 32'h40);
    mem[64] = 32'hA0; mem[65] = 32'hA1; mem[66] = 32'hA2;
    mem[96] = 32'hB0; mem[97] = 32'hB1;
    stall_on = 1'b1;
    wr(O_NEXT, 32'h4C);
    wr(O_CTRL, M2P | B_FE);
    wr(O_CTRL, M2P | B_EN);
    wait_per(8, 3000);
    wr(O_CTRL, M2P);
    idle(40);
    chk("R2 fetch word0", acc_log[0], 32'h40);
    chk("R2 fetch word1", acc_log[1], 32'h44);
    chk("R2 fetch word2", acc_log[2], 32'h48);
    chk("R2 fetch word3", acc_log[3], 32'h4C);
    chk("R11 first read addr", acc_log[4], 32'h100);
    chk("R11 first write addr", acc_log[5], PER);
    chk("R3 src inc addr", acc_log[6], 32'h104);
    for (int i = 0; i < 8; i++) chk("R5 ring order", per_log[i], exp8[i]);
    rd(O_STAT, v); chk("R5 status set", v, 32'h1);
  endtask

  // R3 R4: peripheral to memory, odd count
  task automatic t_round();
    do_reset();
    put_desc(32'h80, 32'd10, PER, 32'h1C0, 32'h80);
    mem[115] = 32'hDEAD;
    wr(O_MASK, 32'h1);
    wr(O_NEXT, 32'h80);
    wr(O_CTRL, P2M | B_FE);
    wr(O_CTRL, P2M | B_EN);
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    wr(O_CTRL, P2M);
    idle(20);
    chk("R4 word0", mem[112], 32'h0);
    chk("R4 word1", mem[113], 32'h1);
    chk("R4 word2", mem[114], 32'h2);
    chk("R4 no fourth word", mem[115], 32'hDEAD);
    chk("R3 src hold", acc_log[6], PER);
    chk("R3 dst inc", acc_log[7], 32'h1C4);
  endtask

  // R6 R7: mask, sticky status, clear
  task automatic t_irq();
    logic [31:0] v;
    logic        seen;
    do_reset();
    put_desc(32'h40, 32'd4, 32'h100, PER, 32'h60);
    put_desc(32'h60, 32'd4, 32'h104, PER, 32'h40);
    wr(O_NEXT, 32'h40);
    wr(O_CTRL, M2P | B_FE);
    wr(O_CTRL, M2P | B_EN);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk("R6 masked irq stays low", {31'b0, seen}, 32'h0);
    wait_per(4, 500);
    wr(O_CTRL, M2P);
    idle(30);
    rd(O_STAT, v); chk("R7 sticky after several completions", v, 32'h1);
    wr(O_STAT, 32'h1);
    rd(O_STAT, v); chk("R6 writing one no effect", v, 32'h1);
    wr(O_MASK, 32'h1);
    idle(3);
    chk("R6 irq on when unmasked", {31'b0, irq}, 32'h1);
    wr(O_STAT, 32'h0);
    idle(3);
    chk("R6 irq off after clear", {31'b0, irq}, 32'h0);
    rd(O_STAT, v); chk("R7 single clear", v, 32'h0);
  endtask

  // R8 R9: pause and resume, current descriptor, active bit
  task automatic t_pause();
    logic [31:0] v;
    int          n1;
    do_reset();
    put_desc(32'h40, 32'd64, 32'h100, PER, 32'h40);
    for (int i = 0; i < 16; i++) mem[64+i] = 32'h10 + i;
    stall_on = 1'b1;
    wr(O_NEXT, 32'h40);
    wr(O_CTRL, M2P | B_FE);
    idle(40);
    rd(O_CUR, v);  chk("R9 current descriptor", v, 32'h40);
    rd(O_CTRL, v); chk("R9 not active while disabled", v, M2P);
    wr(O_CTRL, M2P | B_EN);
    idle(20);
    rd(O_CTRL, v); chk("R9 active while moving", v, M2P | B_EN | B_AC);
    wr(O_CTRL, M2P);
    idle(20);
    n1 = per_n;
    rd(O_CTRL, v); chk("R9 inactive when paused", v, M2P);
    idle(60);
    chk("R8 no progress while paused", per_n, n1);
    chk("R8 no request while paused", {31'b0, mem_req}, 32'h0);
    wr(O_CTRL, M2P | B_EN);
    wait_per(n1 + 3, 1000);
    for (int i = 0; i < n1 + 3; i++) chk("R8 resume order", per_log[i], 32'h10 + (i % 16));
  endtask

  // R10: abort
  task automatic t_abort();
    logic [31:0] v;
    int          n1;
    do_reset();
    put_desc(32'h40, 32'd64, 32'h100, PER, 32'h40);
    for (int i = 0; i < 16; i++) mem[64+i] = 32'h10 + i;
    wr(O_NEXT, 32'h40);
    wr(O_CTRL, M2P | B_FE);
    wr(O_CTRL, M2P | B_EN);
    wait_per(3, 500);
    wr(O_CTRL, M2P | B_EN | B_AB);
    chk("R10 request dropped", {31'b0, mem_req}, 32'h0);
    n1 = per_n;
    idle(40);
    chk("R10 enable does not restart", per_n, n1);
    rd(O_CTRL, v); chk("R10 active cleared", v, M2P | B_EN);
    wr(O_CTRL, M2P | B_EN | B_FE);
    wait_per(n1 + 2, 500);
    chk("R10 refetch first word", per_log[n1], 32'h10);
    chk("R10 refetch second word", per_log[n1+1], 32'h11);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_ring();
    t_round();
    t_irq();
    t_pause();
    t_abort();
    summary();
    $finish;
  end

endmodule